// File: doc/BRIEF.md
# Zero-Cross Stereo Digital Volume

This block scales two channels of signed PCM audio, left and right, by gains taken from an 8-bit code per channel. Each code step is worth 0.375 dB, so sixteen steps double or halve the level. A one-bit range select picks one of two gain tables. The line table sits 30 dB below the microphone table for every code. Each product is saturated to the sample width before it is registered at the output.

A host writes a new code for a channel through a shared code bus with one write strobe per channel. The code does not act at once. It is held pending until that channel's signal crosses zero, or until a selectable timeout of sample periods expires, whichever comes first. This keeps steps in gain from being heard as clicks. While the path is powered down, and during a fixed initialization run of samples after power-up, the output is held at zero. Any code written in that time is applied at the end of the initialization run.

Top module: `zcv_stereo_volume`

## Requirements
- R1: Left and right have independent codes. The applied code of each channel is visible on `code_left`/`code_right`, resets to 91h, and changes only in a cycle where `smp_valid` is high.
- R2: In the microphone table (`range_sel`=0), the gain is 2^((code-145)/16). So 91h gives unity, F1h gives +36 dB and 01h gives -54 dB.
- R3: Code 00h mutes the channel, and its output is exactly zero.
- R4: In the line table (`range_sel`=1), every code gives 80 steps (30 dB) less gain than in the microphone table. So F1h gives +6 dB and 01h gives -84 dB.
- R5: Codes above F1h give the same gain as F1h.
- R6: Results are saturated to 2^(W-1)-1 and -2^(W-1), where W is the sample width (24 by default).
- R7: A pending code is applied on the first running sample that is zero or whose sign differs from the previous sample of that channel. The new gain already acts on that sample. Until then, the old code stays in force.
- R8: If no crossing occurs, a pending code is applied on the (128 << `tmo_sel`)-th running sample after the write. A new write restarts this count.
- R9: While `path_en` is low, and for the first 8 samples after it rises, outputs are zero, `path_ready` is low and pending codes are not applied. On the 8th sample, pending codes are applied and `path_ready` rises.
- R10: Each sample strobe produces `out_valid` and the scaled results exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| path_en | input | 1 | Path power enable |
| range_sel | input | 1 | Gain table: 0 microphone, 1 line |
| tmo_sel | input | 2 | Timeout choice: 128 << tmo_sel samples |
| wr_left | input | 1 | Write `wr_code` as pending left code |
| wr_right | input | 1 | Write `wr_code` as pending right code |
| wr_code | input | 8 | Gain code to write |
| smp_valid | input | 1 | Sample strobe for both channels |
| in_left | input | 24 | Left input sample, signed |
| in_right | input | 24 | Right input sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 24 | Left scaled sample |
| out_right | output | 24 | Right scaled sample |
| code_left | output | 8 | Left applied code |
| code_right | output | 8 | Right applied code |
| path_ready | output | 1 | Initialization done, path running |

## Verification
The following properties are checked on every cycle:
- the one-cycle output latency;
- zero output while the path is not ready;
- zero output for a muted code;
- the applied code holding steady between sample strobes;
- the applied code holding steady on running samples that have neither a crossing nor a timeout.

Some behaviour can only be shown by the bench's scenarios, where a scoreboard model predicts each output:
- the gain values of both tables;
- clamping of codes above F1h;
- output saturation;
- the exact sample on which a timeout fires, and the restart of the count on a rewrite;
- a deferred code taking effect at the end of initialization.

// File: rtl/zcv_pkg.sv
package zcv_pkg;

  localparam logic [7:0] MAX_CODE   = 8'hF1;
  localparam int         UNITY_CODE = 145;
  localparam int         LINE_DROP  = 80;

  typedef struct packed {
    logic        mute;
    logic [4:0]  rshift;
    logic [16:0] mant;
  } gain_t;

  // 2^(k/16) in Q1.15, rounded
  function automatic logic [16:0] mant_q15(input logic [3:0] k);
    case (k)
      4'd0:    mant_q15 = 17'd32768;
      4'd1:    mant_q15 = 17'd34219;
      4'd2:    mant_q15 = 17'd35734;
      4'd3:    mant_q15 = 17'd37316;
      4'd4:    mant_q15 = 17'd38968;
      4'd5:    mant_q15 = 17'd40693;
      4'd6:    mant_q15 = 17'd42495;
      4'd7:    mant_q15 = 17'd44376;
      4'd8:    mant_q15 = 17'd46341;
      4'd9:    mant_q15 = 17'd48393;
      4'd10:   mant_q15 = 17'd50535;
      4'd11:   mant_q15 = 17'd52773;
      4'd12:   mant_q15 = 17'd55109;
      4'd13:   mant_q15 = 17'd57549;
      4'd14:   mant_q15 = 17'd60097;
      default: mant_q15 = 17'd62757;
    endcase
  endfunction

  // Signed step count relative to unity gain (R2, R4, R5)
  function automatic logic signed [9:0] code_steps(input logic [7:0] code, input logic line);
    logic [7:0] c;
    c = (code > MAX_CODE) ? MAX_CODE : code;
    code_steps = $signed({2'b00, c}) - 10'sd145 - (line ? 10'sd80 : 10'sd0);
  endfunction

  // Split steps into octave shift and mantissa index
  function automatic gain_t decode_gain(input logic [7:0] code, input logic line);
    logic signed [9:0] s;
    logic signed [5:0] q;
    gain_t g;
    s        = code_steps(code, line);
    q        = $signed(s[9:4]);
    g.mute   = (code == 8'h00);
    g.mant   = mant_q15(s[3:0]);
    g.rshift = 5'(6'sd15 - q);
    decode_gain = g;
  endfunction

endpackage

// File: rtl/zcv_init_seq.sv
module zcv_init_seq #(
  parameter int INIT_SAMPLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  input  logic path_en,
  output logic ready,
  output logic init_fire
);
  localparam int CW = $clog2(INIT_SAMPLES + 1);

  logic [CW-1:0] cnt;

  assign init_fire = smp && path_en && !ready && (cnt == CW'(INIT_SAMPLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      cnt   <= '0;
    end else if (!path_en) begin
      ready <= 1'b0;
      cnt   <= '0;
    end else if (init_fire) begin
      ready <= 1'b1;
      cnt   <= '0;
    end else if (smp && !ready) begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/zcv_update_ctrl.sv
module zcv_update_ctrl #(
  parameter int         TMO_BASE   = 128,
  parameter int         TMO_W      = 11,
  parameter logic [7:0] RESET_CODE = 8'h91
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp,
  input  logic             run,
  input  logic             init_fire,
  input  logic             wr,
  input  logic [7:0]       wr_code,
  input  logic [1:0]       tmo_sel,
  input  logic             din_neg,
  input  logic             din_zero,
  output logic [7:0]       cur_code,
  output logic [7:0]       used_code,
  output logic             zc_ev,
  output logic             tmo_ev
);
  logic [7:0]       pend_code;
  logic             pend;
  logic             prev_neg;
  logic [TMO_W-1:0] cnt;
  logic [TMO_W-1:0] limit;
  logic             apply;

  assign limit     = TMO_W'(TMO_BASE) << tmo_sel;
  assign zc_ev     = din_zero || (din_neg != prev_neg);
  assign tmo_ev    = pend && ((cnt + 1'b1) >= limit);
  assign apply     = smp && run && pend && !wr && (zc_ev || tmo_ev);
  assign used_code = apply ? pend_code : cur_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_code  <= RESET_CODE;
      pend_code <= RESET_CODE;
      pend      <= 1'b0;
      cnt       <= '0;
    end else if (wr) begin
      pend_code <= wr_code;
      pend      <= 1'b1;
      cnt       <= '0;
    end else if (init_fire && pend) begin
      cur_code  <= pend_code;
      pend      <= 1'b0;
    end else if (apply) begin
      cur_code  <= pend_code;
      pend      <= 1'b0;
    end else if (smp && run && pend) begin
      cnt       <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev_neg <= 1'b0;
    else if (smp) prev_neg <= din_neg;
  end
endmodule

// File: rtl/zcv_gain_path.sv
module zcv_gain_path #(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp,
  input  logic                     run,
  input  logic                     line,
  input  logic [7:0]               code,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] dout
);
  import zcv_pkg::*;

  localparam int PW = DATA_W + 18;
  localparam logic signed [PW-1:0] SMAX = {{(PW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PW-1:0] SMIN = {{(PW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  gain_t                   g;
  logic signed [PW-1:0]    prod;
  logic signed [PW-1:0]    scaled;
  logic signed [DATA_W-1:0] result;

  always_comb begin
    g      = decode_gain(code, line);
    prod   = PW'(din) * $signed({{(PW-17){1'b0}}, g.mant});
    scaled = prod >>> g.rshift;
    if (!run || g.mute)   result = '0;
    else if (scaled > SMAX) result = SMAX[DATA_W-1:0];
    else if (scaled < SMIN) result = SMIN[DATA_W-1:0];
    else                    result = scaled[DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dout <= '0;
    else if (smp) dout <= result;
  end
endmodule

// File: rtl/zcv_stereo_volume.sv
module zcv_stereo_volume #(
  parameter int         DATA_W       = 24,
  parameter int         TMO_BASE     = 128,
  parameter int         INIT_SAMPLES = 8,
  parameter logic [7:0] RESET_CODE   = 8'h91
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     path_en,
  input  logic                     range_sel,
  input  logic [1:0]               tmo_sel,
  input  logic                     wr_left,
  input  logic                     wr_right,
  input  logic [7:0]               wr_code,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic [7:0]               code_left,
  output logic [7:0]               code_right,
  output logic                     path_ready
);
  localparam int NCH   = 2;
  localparam int TMO_W = $clog2(TMO_BASE * 8) + 1;

  logic                                 init_fire;
  logic [NCH-1:0]                       wr_ch;
  logic [NCH-1:0][DATA_W-1:0]           din_ch;
  logic [NCH-1:0][DATA_W-1:0]           dout_ch;
  logic [NCH-1:0][7:0]                  cur_code;
  logic [NCH-1:0][7:0]                  used_code;
  logic [NCH-1:0]                       zc_ev;
  logic [NCH-1:0]                       tmo_ev;

  assign wr_ch  = {wr_right, wr_left};
  assign din_ch = {in_right, in_left};

  zcv_init_seq #(.INIT_SAMPLES(INIT_SAMPLES)) init_i (
    .clk(clk), .rst_n(rst_n), .smp(smp_valid), .path_en(path_en),
    .ready(path_ready), .init_fire(init_fire)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    zcv_update_ctrl #(.TMO_BASE(TMO_BASE), .TMO_W(TMO_W), .RESET_CODE(RESET_CODE)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .smp(smp_valid), .run(path_ready),
      .init_fire(init_fire), .wr(wr_ch[ch]), .wr_code(wr_code), .tmo_sel(tmo_sel),
      .din_neg(din_ch[ch][DATA_W-1]), .din_zero(din_ch[ch] == '0),
      .cur_code(cur_code[ch]), .used_code(used_code[ch]),
      .zc_ev(zc_ev[ch]), .tmo_ev(tmo_ev[ch])
    );

    zcv_gain_path #(.DATA_W(DATA_W)) gain_i (
      .clk(clk), .rst_n(rst_n), .smp(smp_valid), .run(path_ready),
      .line(range_sel), .code(used_code[ch]), .din($signed(din_ch[ch])),
      .dout(dout_ch[ch])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= smp_valid;
  end

  assign out_left   = dout_ch[0];
  assign out_right  = dout_ch[1];
  assign code_left  = cur_code[0];
  assign code_right = cur_code[1];
endmodule

// File: rtl/zcv_checker.sv
module zcv_checker #(
  parameter int DATA_W = 24,
  parameter int NCH    = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     smp_valid,
  input logic                     out_valid,
  input logic                     path_ready,
  input logic signed [DATA_W-1:0] out_left,
  input logic signed [DATA_W-1:0] out_right,
  input logic [7:0]               code_left,
  input logic [7:0]               code_right,
  input logic [NCH-1:0][7:0]      used_code,
  input logic [NCH-1:0]           zc_ev,
  input logic [NCH-1:0]           tmo_ev
);
  p_valid_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> out_valid);
  p_no_stray_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !out_valid);
  p_zero_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !path_ready) |=> (out_left == '0 && out_right == '0));
  p_mute_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && used_code[0] == 8'h00) |=> (out_left == '0));
  p_mute_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && used_code[1] == 8'h00) |=> (out_right == '0));
  p_code_on_sample_left_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(code_left));
  p_code_on_sample_right_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(code_right));
  p_hold_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && path_ready && !zc_ev[0] && !tmo_ev[0]) |=> $stable(code_left));
  p_hold_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && path_ready && !zc_ev[1] && !tmo_ev[1]) |=> $stable(code_right));
endmodule

bind zcv_stereo_volume zcv_checker #(.DATA_W(DATA_W), .NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .out_valid(out_valid),
  .path_ready(path_ready), .out_left(out_left), .out_right(out_right),
  .code_left(code_left), .code_right(code_right), .used_code(used_code),
  .zc_ev(zc_ev), .tmo_ev(tmo_ev)
);

// File: tb/zcv_stereo_volume_tb.sv
`timescale 1ns/1ps
module zcv_stereo_volume_tb_top;
  localparam int DW   = 24;
  localparam int INIT = 8;
  localparam real FS_MAX = 8388607.0;
  localparam real FS_MIN = -8388608.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic path_en = 1'b0, range_sel = 1'b0, wr_left = 1'b0, wr_right = 1'b0, smp_valid = 1'b0;
  logic [1:0] tmo_sel = 2'd0;
  logic [7:0] wr_code = 8'h00;
  logic signed [DW-1:0] in_left = '0, in_right = '0;
  logic out_valid, path_ready;
  logic signed [DW-1:0] out_left, out_right;
  logic [7:0] code_left, code_right;

  always #2.5 clk = ~clk;

  zcv_stereo_volume dut_i (
    .clk(clk), .rst_n(rst_n), .path_en(path_en), .range_sel(range_sel), .tmo_sel(tmo_sel),
    .wr_left(wr_left), .wr_right(wr_right), .wr_code(wr_code), .smp_valid(smp_valid),
    .in_left(in_left), .in_right(in_right), .out_valid(out_valid), .out_left(out_left),
    .out_right(out_right), .code_left(code_left), .code_right(code_right), .path_ready(path_ready)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // scoreboard
  real   q_l[$], q_r[$];
  string q_t[$];

  // reference model state
  int m_cur[2], m_pend[2], m_cnt[2];
  bit m_pf[2], m_neg[2];
  bit m_path = 0, m_ready = 0, m_line = 0;
  int m_icnt = 0, m_sel = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic real expect_val(input int x, input int code, input bit line);
    int c; real v;
    if (code == 0) return 0.0;
    c = (code > 241) ? 241 : code;
    v = real'(x) * (2.0 ** (real'(c - 145 - (line ? 80 : 0)) / 16.0));
    if (v > FS_MAX) v = FS_MAX;
    if (v < FS_MIN) v = FS_MIN;
    return v;
  endfunction

  task automatic send(input int xl, input int xr, input string tag);
    int xs[2]; real e[2]; bit run; int used; bit zc;
    xs[0] = xl; xs[1] = xr;
    run = m_path && m_ready;
    for (int ch = 0; ch < 2; ch++) begin
      used = m_cur[ch];
      if (run && m_pf[ch]) begin
        zc = (xs[ch] == 0) || ((xs[ch] < 0) != m_neg[ch]);
        if (zc || (m_cnt[ch] + 1 >= (128 << m_sel))) begin
          m_cur[ch] = m_pend[ch]; m_pf[ch] = 0; used = m_pend[ch];
        end else m_cnt[ch]++;
      end
      e[ch] = run ? expect_val(xs[ch], used, m_line) : 0.0;
      m_neg[ch] = xs[ch] < 0;
    end
    if (m_path && !m_ready) begin
      if (m_icnt == INIT - 1) begin
        m_ready = 1; m_icnt = 0;
        for (int ch = 0; ch < 2; ch++) if (m_pf[ch]) begin m_cur[ch] = m_pend[ch]; m_pf[ch] = 0; end
      end else m_icnt++;
    end
    q_l.push_back(e[0]); q_r.push_back(e[1]); q_t.push_back(tag);
    @(negedge clk);
    smp_valid = 1'b1; in_left = DW'(xl); in_right = DW'(xr);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic write_code(input int ch, input int code);
    @(negedge clk);
    wr_code = 8'(code);
    if (ch == 0) wr_left = 1'b1; else wr_right = 1'b1;
    m_pend[ch] = code; m_pf[ch] = 1; m_cnt[ch] = 0;
    @(negedge clk);
    wr_left = 1'b0; wr_right = 1'b0;
  endtask

  task automatic set_path(input bit en);
    @(negedge clk);
    path_en = en; m_path = en;
    if (!en) begin m_ready = 0; m_icnt = 0; end
  endtask

  function automatic bit close(input int act, input real exp);
    real d, tol;
    if (exp == FS_MAX || exp == FS_MIN || exp == 0.0) return real'(act) == exp;
    d = real'(act) - exp; if (d < 0) d = -d;
    tol = 2.0 + ((exp < 0) ? -exp : exp) / 4096.0;
    return d <= tol;
  endfunction

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (q_l.size() == 0) chk(0, "R10 unexpected output", 0, 0);
        else begin
          real el, er; string t;
          el = q_l.pop_front(); er = q_r.pop_front(); t = q_t.pop_front();
          chk(close(out_left, el), {t, " left"}, out_left, int'(el));
          chk(close(out_right, er), {t, " right"}, out_right, int'(er));
        end
      end
    end
  end

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 150000);
    chk(0, "watchdog", 0, 1);
    finish_sim();
  end

  initial begin
    for (int ch = 0; ch < 2; ch++) begin
      m_cur[ch] = 145; m_pend[ch] = 145; m_cnt[ch] = 0; m_pf[ch] = 0; m_neg[ch] = 0;
    end
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(code_left == 8'h91 && code_right == 8'h91, "R1 reset codes", code_left, 145);
    chk(!out_valid && !path_ready, "R9 reset idle", path_ready, 0);
    rst_n = 1'b1;

    // R9 initialization run
    set_path(1);
    for (int i = 0; i < INIT - 1; i++) send(1000, 2000, "R9 init zero");
    chk(!path_ready, "R9 ready early", path_ready, 0);
    send(1000, 2000, "R9 init zero");
    chk(path_ready, "R9 ready after init", path_ready, 1);

    // R2 unity
    send(1000, -2000, "R2 unity");
    send(123456, -7, "R2 unity");

    // R7 zero crossing
    write_code(0, 8'hA1);
    write_code(1, 8'h81);
    send(5000, 5000, "R7 crossing right");
    chk(code_right == 8'h81, "R7 right applied", code_right, 8'h81);
    chk(code_left == 8'h91, "R7 left held", code_left, 8'h91);
    send(-5000, -5000, "R7 crossing left");
    chk(code_left == 8'hA1, "R7 left applied", code_left, 8'hA1);

    // R8 timeout and restart
    write_code(0, 8'hB1);
    for (int i = 0; i < 127; i++) send(-3000, -3000, "R8 waiting");
    chk(code_left == 8'hA1, "R8 before timeout", code_left, 8'hA1);
    send(-3000, -3000, "R8 timeout");
    chk(code_left == 8'hB1, "R8 at timeout", code_left, 8'hB1);
    write_code(0, 8'hC1);
    for (int i = 0; i < 100; i++) send(-3000, -3000, "R8 waiting");
    write_code(0, 8'hD1);
    for (int i = 0; i < 100; i++) send(-3000, -3000, "R8 waiting");
    chk(code_left == 8'hB1, "R8 restart on write", code_left, 8'hB1);
    for (int i = 0; i < 28; i++) send(-3000, -3000, "R8 waiting");
    chk(code_left == 8'hD1, "R8 after restart", code_left, 8'hD1);
    @(negedge clk); tmo_sel = 2'd1; m_sel = 1;
    write_code(1, 8'h91);
    for (int i = 0; i < 255; i++) send(-100, -3000, "R8 long wait");
    chk(code_right == 8'h81, "R8 sel1 before", code_right, 8'h81);
    send(-100, -3000, "R8 sel1 timeout");
    chk(code_right == 8'h91, "R8 sel1 at timeout", code_right, 8'h91);

    // R3 mute via zero sample
    write_code(0, 8'h00);
    send(0, -100, "R3 mute zero sample");
    chk(code_left == 8'h00, "R3 mute applied", code_left, 0);
    send(-77777, -100, "R3 mute output");

    // R5 clamp above F1
    write_code(0, 8'hFF);
    write_code(1, 8'hF1);
    send(0, 0, "R5 apply");
    send(1000, 1000, "R5 FF equals F1");
    // R6 saturation
    send(8000000, -8000000, "R6 saturation");
    send(-8000000, 8000000, "R6 saturation");

    // R4 line table
    @(negedge clk); range_sel = 1'b1; m_line = 1;
    send(1000, -1000, "R4 line F1");
    write_code(1, 8'h01);
    send(0, 0, "R4 apply");
    send(8388607, 8388607, "R4 line 01");

    // R9 deferred write across power-down
    @(negedge clk); range_sel = 1'b0; m_line = 0;
    set_path(0);
    write_code(0, 8'h91);
    for (int i = 0; i < 3; i++) send(-500, 500, "R9 down zero");
    chk(code_left == 8'hFF, "R9 held while down", code_left, 8'hFF);
    set_path(1);
    for (int i = 0; i < INIT - 1; i++) send(-500, 500, "R9 init zero");
    chk(code_left == 8'hFF, "R9 held during init", code_left, 8'hFF);
    send(-500, 500, "R9 init zero");
    chk(code_left == 8'h91, "R9 applied at init end", code_left, 8'h91);
    send(4321, 4321, "R9 running unity");

    repeat (4) @(negedge clk);
    chk(q_l.size() == 0, "R10 all outputs seen", q_l.size(), 0);
    finish_sim();
  end
endmodule